// File: doc/BRIEF.md
# Instruction Cache Miss Fill Controller

This block sits between the fetch stage of a pipeline and a read-only instruction cache. Each cycle the fetch stage presents an address, and the tag array beside the block reports whether that address hits. On a hit the instruction read from the data array passes straight to the instruction register. On a miss the block holds the pipeline stalled and feeds a no-operation encoding to the instruction register. It captures the missing line address and fetches the line from memory one word at a time. The word the fetch stage asked for comes first, and the rest follow in wrap-around order.

Returned words collect in an internal line buffer. Once all of them have arrived, the block copies the buffer into the data array one word per cycle. Only after that does it write the tag, which is also what marks the line valid, so the line can never look valid while its data is partly old. In the cycle after the tag write the stall drops and the requested instruction is delivered from the line buffer. The block then returns to idle, and the refetch of the same address hits. Nothing but this block ever writes the cache.

Top module: `icMissFill`

## Requirements
- R1: While reset is held and in the first idle cycles after it, with no fetch presented, `stall`, `memReq`, `dataWe` and `tagWe` are all low.
- R2: In the idle state, a fetch whose tag check hits gives `stall` low and `irData` equal to `hitInstr` in the same cycle.
- R3: A fetch that misses in the idle state raises `stall` in that same cycle. From then until the delivery cycle, `stall` stays high and `irData` equals the `NOP_WORD` parameter.
- R4: The first memory request of a fill is for the word address that missed: the line address in the upper bits and the missed word index in the low log2(WORDS) bits.
- R5: Word k of the fill (k = 0..WORDS-1) is requested at word index (critical index + k) mod WORDS of the same line, and exactly WORDS requests are made.
- R6: Once `memReq` is raised, it and `memAddr` stay unchanged until a cycle with `memValid` high. `memValid` has no effect while `memReq` is low.
- R7: After the last word arrives, the data array is written on WORDS consecutive cycles with word index 0, 1, ... WORDS-1, each carrying the word memory returned for that index.
- R8: The tag array is written exactly once per miss, with the line's tag and set. This happens in the cycle right after the last data-array write and never before every word of the line has been written.
- R9: In the cycle after the tag write, `stall` is low and `irData` is the word at the originally missed address. The following cycle is idle, and a fetch of that address hits.
- R10: While a fill is in progress, changes of `fetchAddr` or `fetchValid` start no new fill and do not change the line being fetched, written or delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchValid | input | 1 | Fetch stage presents an address |
| fetchAddr | input | ADDR_W | Word address of the fetch |
| tagHit | input | 1 | Tag array lookup of `fetchAddr` hit a valid line |
| hitInstr | input | WORD_W | Data array word at `fetchAddr` |
| stall | output | 1 | Hold the fetch stage |
| irData | output | WORD_W | Instruction to the instruction register |
| memReq | output | 1 | Word request to memory, held until answered |
| memAddr | output | ADDR_W | Word address of the request |
| memValid | input | 1 | Memory returns the requested word |
| memData | input | WORD_W | Returned word |
| dataWe | output | 1 | Data array write strobe |
| dataSet | output | log2(SETS) | Set written in the data array |
| dataWord | output | log2(WORDS) | Word index written in the data array |
| dataWdata | output | WORD_W | Word written in the data array |
| tagWe | output | 1 | Tag array write strobe, sets the valid bit |
| tagSet | output | log2(SETS) | Set written in the tag array |
| tagValue | output | ADDR_W-log2(SETS)-log2(WORDS) | Tag written |

## Verification
The bench builds the block with an 8-bit word address, four words per line and four sets. This is small enough to take a miss at every word offset of every set, so every critical index and every wrap of the request order is covered. Each miss uses a new tag, so it also evicts the line the previous miss installed. Memory latency varies between one and three cycles per word. One miss in each set moves the fetch address in mid-fill, and a stray `memValid` pulse is sent while the block is idle.

// File: rtl/icFillPkg.sv
package icFillPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WRDATA,
    ST_WRTAG,
    ST_DONE
  } fillState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch the missing address
    logic storeWord;  // a memory word is arriving
    logic writeStep;  // one data-array word is being written
    logic selNop;     // drive the no-operation encoding
    logic selFill;    // deliver the critical word from the line buffer
  } fillStrobe_t;

endpackage

// File: rtl/icFillCtrl.sv
module icFillCtrl
  import icFillPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        fetchValid,
  input  logic        tagHit,
  input  logic        memValid,
  input  logic        lastWord,
  output fillStrobe_t strobe,
  output logic        memReq,
  output logic        dataWe,
  output logic        tagWe,
  output logic        stall
);

  fillState_e state, stateNext;
  logic missNow;

  always_comb begin
    missNow = (state == ST_IDLE) && fetchValid && !tagHit;
    stall   = missNow || (state == ST_FETCH) || (state == ST_WRDATA) || (state == ST_WRTAG);
    memReq  = (state == ST_FETCH);
    dataWe  = (state == ST_WRDATA);
    tagWe   = (state == ST_WRTAG);

    strobe.capture   = missNow;
    strobe.storeWord = (state == ST_FETCH) && memValid;
    strobe.writeStep = (state == ST_WRDATA);
    strobe.selNop    = stall;
    strobe.selFill   = (state == ST_DONE);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (missNow) stateNext = ST_FETCH;
      ST_FETCH:  if (memValid && lastWord) stateNext = ST_WRDATA;
      ST_WRDATA: if (lastWord) stateNext = ST_WRTAG;
      ST_WRTAG:  stateNext = ST_DONE;
      ST_DONE:   stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R8
  tag_after_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    tagWe |-> $past(dataWe));

  // R9
  release_after_tag_chk: assert property (@(posedge clk) disable iff (!rstN)
    tagWe |=> !stall);

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memValid |=> memReq);

endmodule

// File: rtl/icFillPath.sv
module icFillPath
  import icFillPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int SETS   = 16,
  parameter logic [WORD_W-1:0] NOP_WORD = 'h13,
  localparam int OFF_W  = $clog2(WORDS),
  localparam int IDX_W  = $clog2(SETS),
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int TAG_W  = LINE_W - IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  fillStrobe_t       strobe,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [WORD_W-1:0] memData,
  input  logic [WORD_W-1:0] hitInstr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [IDX_W-1:0]  dataSet,
  output logic [OFF_W-1:0]  dataWord,
  output logic [WORD_W-1:0] dataWdata,
  output logic [TAG_W-1:0]  tagValue,
  output logic [WORD_W-1:0] irData,
  output logic              lastWord
);

  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORDS - 1);

  logic [LINE_W-1:0] lineAddr;
  logic [OFF_W-1:0]  critIdx;
  logic [OFF_W-1:0]  reqIdx;
  logic [OFF_W-1:0]  cnt;
  logic [WORD_W-1:0] bufWords [WORDS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineAddr <= '0;
      critIdx  <= '0;
      reqIdx   <= '0;
      cnt      <= '0;
    end else if (strobe.capture) begin
      lineAddr <= fetchAddr[ADDR_W-1:OFF_W];
      critIdx  <= fetchAddr[OFF_W-1:0];
      reqIdx   <= fetchAddr[OFF_W-1:0];
      cnt      <= '0;
    end else if (strobe.storeWord) begin
      reqIdx <= (reqIdx == LAST_OFF) ? '0 : reqIdx + 1'b1;
      cnt    <= (cnt == LAST_OFF) ? '0 : cnt + 1'b1;
    end else if (strobe.writeStep) begin
      cnt <= (cnt == LAST_OFF) ? '0 : cnt + 1'b1;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_buf
    logic [WORD_W-1:0] wordQ;
    always_ff @(posedge clk) begin
      if (strobe.storeWord && reqIdx == OFF_W'(w)) wordQ <= memData;
    end
    assign bufWords[w] = wordQ;
  end

  assign lastWord  = (cnt == LAST_OFF);
  assign memAddr   = {lineAddr, reqIdx};
  assign dataSet   = lineAddr[IDX_W-1:0];
  assign tagValue  = lineAddr[LINE_W-1:IDX_W];
  assign dataWord  = cnt;
  assign dataWdata = bufWords[cnt];

  always_comb begin
    if (strobe.selNop)       irData = NOP_WORD;
    else if (strobe.selFill) irData = bufWords[critIdx];
    else                     irData = hitInstr;
  end

  // R5
  wrap_complete_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.storeWord && lastWord |=> reqIdx == critIdx);

  // R7
  write_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeStep && !lastWord |=> strobe.writeStep && cnt == $past(cnt) + 1'b1);

endmodule

// File: rtl/icMissFill.sv
module icMissFill
  import icFillPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int SETS   = 16,
  parameter logic [WORD_W-1:0] NOP_WORD = 'h13,
  localparam int OFF_W = $clog2(WORDS),
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              tagHit,
  input  logic [WORD_W-1:0] hitInstr,
  output logic              stall,
  output logic [WORD_W-1:0] irData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [WORD_W-1:0] memData,
  output logic              dataWe,
  output logic [IDX_W-1:0]  dataSet,
  output logic [OFF_W-1:0]  dataWord,
  output logic [WORD_W-1:0] dataWdata,
  output logic              tagWe,
  output logic [IDX_W-1:0]  tagSet,
  output logic [TAG_W-1:0]  tagValue
);

  fillStrobe_t strobe;
  logic lastWord;

  icFillCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .tagHit(tagHit),
    .memValid(memValid), .lastWord(lastWord), .strobe(strobe),
    .memReq(memReq), .dataWe(dataWe), .tagWe(tagWe), .stall(stall)
  );

  icFillPath #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS), .SETS(SETS), .NOP_WORD(NOP_WORD)
  ) path_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fetchAddr(fetchAddr),
    .memData(memData), .hitInstr(hitInstr), .memAddr(memAddr),
    .dataSet(dataSet), .dataWord(dataWord), .dataWdata(dataWdata),
    .tagValue(tagValue), .irData(irData), .lastWord(lastWord)
  );

  assign tagSet = dataSet;

  // R3
  nop_on_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> irData == NOP_WORD);

  // R6
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memValid |=> $stable(memAddr));

endmodule

// File: tb/icMissFill_tb_top.sv
module icMissFill_tb_top;

  localparam int ADDR_W = 8;
  localparam int WORD_W = 32;
  localparam int WORDS  = 4;
  localparam int SETS   = 4;
  localparam logic [31:0] NOP = 32'h0000_0013;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fetchValid = 1'b0;
  logic [7:0] fetchAddr = '0;
  logic tagHit;
  logic [31:0] hitInstr;
  logic stall;
  logic [31:0] irData;
  logic memReq;
  logic [7:0] memAddr;
  logic memValid;
  logic [31:0] memData;
  logic dataWe;
  logic [1:0] dataSet;
  logic [1:0] dataWord;
  logic [31:0] dataWdata;
  logic tagWe;
  logic [1:0] tagSet;
  logic [3:0] tagValue;

  always #2.5 clk = ~clk;

  icMissFill #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS), .SETS(SETS), .NOP_WORD(NOP)
  ) dut_i (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .tagHit(tagHit), .hitInstr(hitInstr), .stall(stall), .irData(irData),
    .memReq(memReq), .memAddr(memAddr), .memValid(memValid), .memData(memData),
    .dataWe(dataWe), .dataSet(dataSet), .dataWord(dataWord), .dataWdata(dataWdata),
    .tagWe(tagWe), .tagSet(tagSet), .tagValue(tagValue)
  );

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] memWord(input logic [7:0] a);
    return {a, 8'hA5, ~a, 8'h3C};
  endfunction

  // stub arrays: set = addr[3:2], word = addr[1:0], tag = addr[7:4]
  logic        tagVld [SETS];
  logic [3:0]  tagArr [SETS];
  logic [31:0] dataArr [SETS*WORDS];

  assign tagHit   = tagVld[fetchAddr[3:2]] && (tagArr[fetchAddr[3:2]] == fetchAddr[7:4]);
  assign hitInstr = dataArr[fetchAddr[3:0]];

  // memory stub and logs
  int          cyc = 0;
  int          reqN = 0, wrN = 0, tagN = 0, lastDataCyc = -10;
  logic [7:0]  reqLog [16];
  logic [1:0]  wrLog [16];
  logic [3:0]  wroteMask = '0;
  bit          addrBad = 0;
  int          waitLeft = -1;
  int          latSeed = 0;
  logic [7:0]  curReq = '0;
  logic        stubValid = 1'b0;
  logic [31:0] stubData = '0;
  logic        spurValid = 1'b0;

  assign memValid = stubValid | spurValid;
  assign memData  = spurValid ? 32'hDEAD_BEEF : stubData;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    stubValid = 1'b0;
    if (memReq) begin
      if (waitLeft < 0) begin
        curReq = memAddr;
        waitLeft = 1 + ((int'(memAddr) + latSeed) % 3);
        if (reqN < 16) reqLog[reqN] = memAddr;
        reqN++;
      end else if (memAddr != curReq) addrBad = 1;
      waitLeft--;
      if (waitLeft == 0) begin
        stubValid = 1'b1;
        stubData  = memWord(curReq);
        waitLeft  = -1;
      end
    end
    if (dataWe) begin
      dataArr[{dataSet, dataWord}] = dataWdata;
      if (wrN < 16) wrLog[wrN] = dataWord;
      wrN++;
      wroteMask[dataWord] = 1'b1;
      lastDataCyc = cyc;
    end
    if (tagWe) begin
      // R8: valid bit only after every data word, right after the last one
      chk(wroteMask == 4'hF && lastDataCyc == cyc - 1, "R8 tag write order",
          {28'd0, wroteMask}, 32'hF);
      tagVld[tagSet] = 1'b1;
      tagArr[tagSet] = tagValue;
      tagN++;
    end
  end

  task automatic doHit(input logic [7:0] a);
    @(negedge clk);
    fetchValid = 1'b1;
    fetchAddr  = a;
    #1;
    // R2
    chk(!stall && irData == memWord(a), "R2 hit delivery", irData, memWord(a));
  endtask

  task automatic runMiss(input logic [7:0] a, input bit moveAddr);
    bit nopBad = 0;
    int n = 0;
    reqN = 0; wrN = 0; tagN = 0; wroteMask = '0; addrBad = 0;
    @(negedge clk);
    fetchValid = 1'b1;
    fetchAddr  = a;
    #1;
    // R3
    chk(stall && irData == NOP, "R3 stall on miss", irData, NOP);
    forever begin
      @(negedge clk);
      if (moveAddr && n == 2) fetchAddr = a ^ 8'hF0;
      if (moveAddr && n == 4) fetchValid = 1'b0;
      if (moveAddr && n == 6) fetchValid = 1'b1;
      #1;
      if (!stall) break;
      if (irData != NOP) nopBad = 1;
      n++;
      if (n > 200) begin
        chk(0, "R9 fill never ends", n, 0);
        break;
      end
    end
    chk(!nopBad, "R3 nop held during stall", nopBad, 0);
    // R9 (R10 when the address moved mid-fill)
    chk(irData == memWord(a), moveAddr ? "R10 delivery after moved fetch" : "R9 critical word delivery",
        irData, memWord(a));
    chk(reqN == WORDS, "R5 request count", reqN, WORDS);
    // R4
    chk(reqLog[0] == a, "R4 critical word first", reqLog[0], a);
    for (int k = 1; k < WORDS; k++) begin
      logic [7:0] e;
      e = {a[7:2], 2'(a[1:0] + k)};
      chk(reqLog[k] == e, "R5 wrap order", reqLog[k], e);
    end
    // R6
    chk(!addrBad, "R6 request held stable", addrBad, 0);
    chk(wrN == WORDS, "R7 data write count", wrN, WORDS);
    for (int k = 0; k < WORDS; k++)
      chk(wrLog[k] == 2'(k), "R7 data write index", wrLog[k], k);
    chk(tagN == 1 && tagArr[a[3:2]] == a[7:4] && tagVld[a[3:2]],
        moveAddr ? "R10 tag of original line" : "R8 tag value", tagArr[a[3:2]], a[7:4]);
    // R9: the next cycle is idle and the same fetch hits
    @(negedge clk);
    fetchValid = 1'b1;
    fetchAddr  = a;
    #1;
    chk(!stall && irData == memWord(a), "R9 refetch hits", irData, memWord(a));
  endtask

  initial begin
    for (int s = 0; s < SETS; s++) begin
      tagVld[s] = 1'b0;
      tagArr[s] = '0;
    end
    for (int i = 0; i < SETS*WORDS; i++) dataArr[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    // R1
    chk(!stall && !memReq && !dataWe && !tagWe, "R1 reset outputs",
        {stall, memReq, dataWe, tagWe}, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk(!stall && !memReq && !dataWe && !tagWe, "R1 idle after reset",
        {stall, memReq, dataWe, tagWe}, 0);
    // R6: a stray memValid while idle must change nothing
    @(negedge clk);
    spurValid = 1'b1;
    @(negedge clk);
    spurValid = 1'b0;
    #1;
    chk(!memReq && !dataWe && !tagWe && !stall, "R6 stray valid ignored",
        {stall, memReq, dataWe, tagWe}, 0);
    for (int s = 0; s < SETS; s++) begin
      for (int off = 0; off < WORDS; off++) begin
        logic [3:0] t;
        logic [7:0] a;
        t = 4'((s * WORDS + off + 1) % 16);
        a = {t, 2'(s), 2'(off)};
        latSeed = s + off;
        runMiss(a, off == 2);
        for (int o = 0; o < WORDS; o++) doHit({t, 2'(s), 2'(o)});
        @(negedge clk);
        fetchValid = 1'b0;
      end
    end
    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

endmodule